// File: doc/BRIEF.md
# Indexed Register Port with Interrupt Status

This block is the byte-wide host side of a clock/calendar peripheral. The host sees only two addresses. A write to the even address picks one of 128 locations. Reads and writes at the odd address then reach the picked location.

Four of the locations are control and status registers. They sit at four consecutive indices starting at `A_IDX`, default 10, and are named A, B, C and D below. Every other index is plain byte storage.

Three flag strobes come in from the neighbouring timekeeping and periodic-tick logic: update-ended, alarm and periodic. The block merges them into the status register (C), compares them against the enable register (B) and drives one level-sensitive interrupt line. Software acknowledges the interrupt by reading C. That read returns the pending flags and clears all of them in one step.

Enabling a source whose flag is already pending raises the interrupt at once. A separate synchronous clear input performs the device reset. It drops the enables and flags without touching time or storage.

Top module: `idxreg_port`

## Requirements
- R1: A write to the even address (bus_addr=0) stores bus_wdata[6:0] as the index, and bit 7 is dropped. A read of the even address returns 0xFF one cycle after the read strobe.
- R2: A write to the odd address at any index other than A_IDX..A_IDX+3 stores the byte. A later read at that index returns it. All storage reads 0x00 after power-up.
- R3: Writes to register C (A_IDX+2) and register D (A_IDX+3) are ignored. D always reads 0x80.
- R4: Bit 7 of register A is read-only and follows uip_in, sampled every clock. A write to A changes only bits 6:0.
- R5: A read of register C returns its value from before the read. After that clock edge, C is 0x00 and irq is low. Flag strobes that arrive in the same cycle as the read are kept for the next read.
- R6: The flag strobes set bits of C as follows: evt_periodic sets bit 6, evt_alarm sets bit 5 and evt_update sets bit 4. When a strobe sets a flag that was clear and whose enable is set, C bit 7 and irq go high. The enables are B bits 6, 5 and 4 respectively. A strobe whose flag is already set, or whose enable is clear, raises nothing.
- R7: A write to register B whose new enables cover an already-set flag sets C bit 7 and irq in the same clock. Any other write to B clears C bit 7 and lowers irq.
- R8: A soft_clr pulse clears B bits 6, 5 and 3 (bit 3 is the square-wave enable) and keeps the other B bits. It also clears C bits 7..4 and lowers irq.
- R9: After rst_n, the registers read A=0x26, B=0x02, C=0x00 and D=0x80, and irq is low.
- R10: irq is a level that always equals C bit 7. It stays high until a read of C, a soft_clr, or a write to B that covers no pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| soft_clr | input | 1 | Synchronous device reset of the enables and flags |
| wr_stb | input | 1 | Bus write strobe, one cycle per access |
| rd_stb | input | 1 | Bus read strobe, one cycle per access |
| bus_addr | input | 1 | 0 = index address, 1 = data address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after rd_stb and held until the next read |
| uip_in | input | 1 | Update-in-progress level from the timekeeping logic |
| evt_update | input | 1 | Update-ended flag strobe |
| evt_alarm | input | 1 | Alarm flag strobe |
| evt_periodic | input | 1 | Periodic flag strobe |
| irq | output | 1 | Level interrupt request |

## Verification
The checker assumes that wr_stb and rd_stb are never high together. It also assumes that soft_clr never coincides with a bus access. A flag strobe may arrive in any cycle, including a read of C.

The stimulus chooses exactly one operation per cycle: an index write, a data write, a read or an idle cycle. Clear pulses are issued only on idle cycles. Flag strobes and uip_in are drawn freely on every cycle, so same-cycle races between strobes, reads of C and writes to B are all exercised.

// File: rtl/idxreg_pkg.sv
package idxreg_pkg;
   localparam int FLAG_N   = 3;
   localparam int FLAG_LSB = 4;
   localparam int REQ_BIT  = 7;
   localparam int UIP_BIT  = 7;
   localparam logic [7:0] PWR_A = 8'h26;
   localparam logic [7:0] PWR_B = 8'h02;
   localparam logic [7:0] PWR_D = 8'h80;
   // enables removed by soft clear: periodic, alarm, square wave
   localparam logic [7:0] B_CLR_MASK = 8'h68;

   typedef logic [FLAG_N-1:0] flag_vec_t;   // {periodic, alarm, update}

   typedef enum logic [2:0] {
      SEL_A,
      SEL_B,
      SEL_C,
      SEL_D,
      SEL_MEM
   } reg_sel_t;
endpackage

// File: rtl/idxreg_store.sv
module idxreg_store #(
   parameter int DW    = 8,
   parameter int IDX_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] idx,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rd_val
);
   localparam int DEPTH = 1 << IDX_W;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en) begin
         mem[idx] <= wdata;
      end
   end

   assign rd_val = mem[idx];
endmodule

// File: rtl/idxreg_ctrl.sv
module idxreg_ctrl
   import idxreg_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          soft_clr,
   input  logic          wr_a,
   input  logic          wr_b,
   input  logic [DW-1:0] wdata,
   input  logic          uip_in,
   output logic [DW-1:0] reg_a,
   output logic [DW-1:0] reg_b,
   output logic [DW-1:0] reg_d
);
   logic          uip_q;
   logic [DW-2:0] a_low_q;
   logic [DW-1:0] b_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         uip_q   <= PWR_A[UIP_BIT];
         a_low_q <= PWR_A[DW-2:0];
         b_q     <= PWR_B;
      end else begin
         uip_q <= uip_in;
         if (wr_a) a_low_q <= wdata[DW-2:0];
         if (soft_clr)  b_q <= b_q & ~B_CLR_MASK;
         else if (wr_b) b_q <= wdata;
      end
   end

   assign reg_a = {uip_q, a_low_q};
   assign reg_b = b_q;
   assign reg_d = PWR_D;
endmodule

// File: rtl/idxreg_status.sv
module idxreg_status
   import idxreg_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          soft_clr,
   input  logic          rd_c,
   input  logic          wr_b,
   input  logic [DW-1:0] wdata,
   input  flag_vec_t     enables,
   input  flag_vec_t     evt,
   output logic [DW-1:0] reg_c,
   output logic          irq
);
   localparam int FLAG_MSB = FLAG_LSB + FLAG_N - 1;

   flag_vec_t flags_q, base_f, fresh, flags_d;
   logic      req_q, base_r, req_d;

   always_comb begin
      base_f  = rd_c ? '0 : flags_q;
      base_r  = rd_c ? 1'b0 : req_q;
      fresh   = evt & ~base_f;
      flags_d = base_f | evt;
      if (wr_b) req_d = |(wdata[FLAG_MSB:FLAG_LSB] & flags_d);
      else      req_d = base_r | (|(fresh & enables));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
         req_q   <= 1'b0;
      end else if (soft_clr) begin
         flags_q <= '0;
         req_q   <= 1'b0;
      end else begin
         flags_q <= flags_d;
         req_q   <= req_d;
      end
   end

   always_comb begin
      reg_c                    = '0;
      reg_c[REQ_BIT]           = req_q;
      reg_c[FLAG_MSB:FLAG_LSB] = flags_q;
   end

   assign irq = req_q;
endmodule

// File: rtl/idxreg_port.sv
module idxreg_port
   import idxreg_pkg::*;
#(
   parameter int DW    = 8,
   parameter int IDX_W = 7,
   parameter int A_IDX = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          soft_clr,
   input  logic          wr_stb,
   input  logic          rd_stb,
   input  logic          bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   input  logic          uip_in,
   input  logic          evt_update,
   input  logic          evt_alarm,
   input  logic          evt_periodic,
   output logic          irq
);
   localparam int DEPTH = 1 << IDX_W;
   localparam logic [IDX_W-1:0] IX_A = IDX_W'(A_IDX);
   localparam logic [IDX_W-1:0] IX_B = IDX_W'(A_IDX + 1);
   localparam logic [IDX_W-1:0] IX_C = IDX_W'(A_IDX + 2);
   localparam logic [IDX_W-1:0] IX_D = IDX_W'(A_IDX + 3);

   generate
      if (DW != 8) begin : g_bad_dw
         $error("idxreg_port: register bit layout needs DW == 8");
      end
      if (IDX_W < 3 || IDX_W > DW - 1) begin : g_bad_idx
         $error("idxreg_port: IDX_W must lie in 3..DW-1");
      end
      if (A_IDX < 0 || A_IDX + 3 >= DEPTH) begin : g_bad_base
         $error("idxreg_port: control registers fall outside the index space");
      end
   endgenerate

   logic [IDX_W-1:0] idx_q;
   logic             dat_wr, dat_rd;
   reg_sel_t         sel;
   logic [DW-1:0]    reg_a, reg_b, reg_c, reg_d, mem_val, rd_mux, rdata_q;
   flag_vec_t        evt_vec;

   assign dat_wr  = wr_stb & bus_addr;
   assign dat_rd  = rd_stb & bus_addr;
   assign evt_vec = {evt_periodic, evt_alarm, evt_update};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    idx_q <= '0;
      else if (wr_stb && !bus_addr)  idx_q <= bus_wdata[IDX_W-1:0];
   end

   always_comb begin
      unique case (idx_q)
         IX_A:    sel = SEL_A;
         IX_B:    sel = SEL_B;
         IX_C:    sel = SEL_C;
         IX_D:    sel = SEL_D;
         default: sel = SEL_MEM;
      endcase
   end

   idxreg_store #(.DW(DW), .IDX_W(IDX_W)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (dat_wr && sel == SEL_MEM),
      .idx    (idx_q),
      .wdata  (bus_wdata),
      .rd_val (mem_val)
   );

   idxreg_ctrl #(.DW(DW)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_clr (soft_clr),
      .wr_a     (dat_wr && sel == SEL_A),
      .wr_b     (dat_wr && sel == SEL_B),
      .wdata    (bus_wdata),
      .uip_in   (uip_in),
      .reg_a    (reg_a),
      .reg_b    (reg_b),
      .reg_d    (reg_d)
   );

   idxreg_status #(.DW(DW)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_clr (soft_clr),
      .rd_c     (dat_rd && sel == SEL_C),
      .wr_b     (dat_wr && sel == SEL_B),
      .wdata    (bus_wdata),
      .enables  (reg_b[FLAG_LSB+FLAG_N-1:FLAG_LSB]),
      .evt      (evt_vec),
      .reg_c    (reg_c),
      .irq      (irq)
   );

   always_comb begin
      unique case (sel)
         SEL_A:   rd_mux = reg_a;
         SEL_B:   rd_mux = reg_b;
         SEL_C:   rd_mux = reg_c;
         SEL_D:   rd_mux = reg_d;
         default: rd_mux = mem_val;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (rd_stb) rdata_q <= bus_addr ? rd_mux : '1;
   end

   assign bus_rdata = rdata_q;
endmodule

// File: rtl/idxreg_port_chk.sv
module idxreg_port_chk #(
   parameter int IDX_W = 7,
   parameter int A_IDX = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             soft_clr,
   input logic             wr_stb,
   input logic             rd_stb,
   input logic             bus_addr,
   input logic [7:0]       bus_rdata,
   input logic [IDX_W-1:0] idx_q,
   input logic [7:0]       reg_c,
   input logic             evt_any,
   input logic             irq
);
   localparam logic [IDX_W-1:0] IX_B = IDX_W'(A_IDX + 1);
   localparam logic [IDX_W-1:0] IX_C = IDX_W'(A_IDX + 2);
   localparam logic [IDX_W-1:0] IX_D = IDX_W'(A_IDX + 3);

   logic rd_c, wr_b;
   assign rd_c = rd_stb && bus_addr && idx_q == IX_C;
   assign wr_b = wr_stb && bus_addr && idx_q == IX_B;

   AST_EVEN_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb && !bus_addr |=> bus_rdata == 8'hFF);                         // R1
   AST_D_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb && bus_addr && idx_q == IX_D |=> bus_rdata == 8'h80);         // R3
   AST_C_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_c && !evt_any && !soft_clr |=> reg_c == 8'h00 && !irq);           // R5
   AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(evt_any || wr_b));                              // R6
   AST_SOFT_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      soft_clr |=> !irq && reg_c[7:4] == 4'h0);                            // R8
   AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !rd_c && !wr_b && !soft_clr |=> irq);                         // R10
endmodule

bind idxreg_port idxreg_port_chk #(.IDX_W(IDX_W), .A_IDX(A_IDX)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .soft_clr  (soft_clr),
   .wr_stb    (wr_stb),
   .rd_stb    (rd_stb),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .idx_q     (idx_q),
   .reg_c     (reg_c),
   .evt_any   (evt_update | evt_alarm | evt_periodic),
   .irq       (irq)
);

// File: tb/sim_idxreg_port.sv
`timescale 1ns/1ps
module sim_idxreg_port;
   logic       clk = 1'b0, rst_n = 1'b0, soft_clr = 1'b0;
   logic       wr_stb = 1'b0, rd_stb = 1'b0, bus_addr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       uip_in = 1'b0, evt_update = 1'b0, evt_alarm = 1'b0, evt_periodic = 1'b0;
   logic       irq;

   always #5 clk = ~clk;

   idxreg_port u0 (.*);

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   // reference model state
   logic [6:0] m_idx, m_alo;
   logic       m_a7, m_req;
   logic [7:0] m_b, m_rdata;
   logic [2:0] m_flags;
   logic [7:0] m_mem [128];

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_idx = '0; m_alo = 7'h26; m_a7 = 1'b0; m_b = 8'h02;
      m_flags = '0; m_req = 1'b0; m_rdata = '0;
      for (int i = 0; i < 128; i++) m_mem[i] = '0;
   endtask

   function automatic logic [7:0] model_read();
      case (m_idx)
         7'd10:   return {m_a7, m_alo};
         7'd11:   return m_b;
         7'd12:   return {m_req, m_flags, 4'h0};
         7'd13:   return 8'h80;
         default: return m_mem[m_idx];
      endcase
   endfunction

   function automatic string read_tag();
      case (m_idx)
         7'd10:   return "R4";
         7'd12:   return "R5";
         7'd13:   return "R3";
         default: return "R2";
      endcase
   endfunction

   task automatic cyc(bit wr, bit rd, bit ad, logic [7:0] d, logic [2:0] ev, bit uip, bit clr);
      string     tg;
      logic [2:0] bf, fr, nf;
      logic       br, nr;
      @(negedge clk);
      wr_stb = wr; rd_stb = rd; bus_addr = ad; bus_wdata = d;
      {evt_periodic, evt_alarm, evt_update} = ev;
      uip_in = uip; soft_clr = clr;
      @(posedge clk);
      tg = ad ? read_tag() : "R1";
      if (rd) m_rdata = ad ? model_read() : 8'hFF;
      if (clr) begin
         m_flags = '0; m_req = 1'b0;
         m_b = m_b & ~8'h68;
      end else begin
         bf = (rd && ad && m_idx == 7'd12) ? 3'b000 : m_flags;
         br = (rd && ad && m_idx == 7'd12) ? 1'b0 : m_req;
         fr = ev & ~bf;
         nf = bf | ev;
         if (wr && ad && m_idx == 7'd11) nr = |(d[6:4] & nf);
         else                            nr = br | (|(fr & m_b[6:4]));
         m_flags = nf; m_req = nr;
         if (wr && ad && m_idx == 7'd11) m_b = d;
      end
      m_a7 = uip;
      if (wr && ad) begin
         if (m_idx == 7'd10) m_alo = d[6:0];
         else if (m_idx < 7'd10 || m_idx > 7'd13) m_mem[m_idx] = d;
      end
      if (wr && !ad) m_idx = d[6:0];
      #2;
      if (rd) chk(tg, bus_rdata, m_rdata);
      chk("R10", {7'b0, irq}, {7'b0, m_req});
   endtask

   task automatic set_idx(logic [7:0] i);
      cyc(1, 0, 0, i, 3'b000, uip_in, 0);
   endtask
   task automatic wr_dat(logic [7:0] d);
      cyc(1, 0, 1, d, 3'b000, uip_in, 0);
   endtask
   task automatic rd_dat(output logic [7:0] v);
      cyc(0, 1, 1, 8'h00, 3'b000, uip_in, 0);
      v = bus_rdata;
   endtask
   task automatic idle(logic [2:0] ev, bit clr);
      cyc(0, 0, 0, 8'h00, ev, uip_in, clr);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      void'($urandom(32'd4242));
      model_reset();
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      #1 chk("R9", {7'b0, irq}, 8'h00);

      // R9 power-up values
      set_idx(8'd10); rd_dat(v); chk("R9", v, 8'h26);
      set_idx(8'd11); rd_dat(v); chk("R9", v, 8'h02);
      set_idx(8'd12); rd_dat(v); chk("R9", v, 8'h00);
      set_idx(8'd13); rd_dat(v); chk("R9", v, 8'h80);

      // R1 index bit 7 dropped, even read
      set_idx(8'h8A); rd_dat(v); chk("R1", v, 8'h26);
      cyc(0, 1, 0, 8'h00, 3'b000, 0, 0); chk("R1", bus_rdata, 8'hFF);

      // R3 writes to C and D ignored
      set_idx(8'd13); wr_dat(8'h00); rd_dat(v); chk("R3", v, 8'h80);
      set_idx(8'd12); wr_dat(8'hF0); rd_dat(v); chk("R3", v, 8'h00);

      // R4 update-in-progress bit read-only
      set_idx(8'd10); wr_dat(8'h95); rd_dat(v); chk("R4", v, 8'h15);
      uip_in = 1'b1; idle(3'b000, 0); rd_dat(v); chk("R4", v, 8'h95);
      wr_dat(8'h00); rd_dat(v); chk("R4", v, 8'h80);
      uip_in = 1'b0; idle(3'b000, 0);

      // R6 disabled flag raises nothing; R5 read clears
      idle(3'b010, 0); chk("R6", {7'b0, irq}, 8'h00);
      set_idx(8'd12); rd_dat(v); chk("R5", v, 8'h20);
      rd_dat(v); chk("R5", v, 8'h00);
      set_idx(8'd11); wr_dat(8'h20);
      idle(3'b010, 0); chk("R6", {7'b0, irq}, 8'h01);
      idle(3'b010, 0); chk("R10", {7'b0, irq}, 8'h01);
      set_idx(8'd12); rd_dat(v); chk("R5", v, 8'hA0);
      chk("R5", {7'b0, irq}, 8'h00);

      // R7 enabling an already pending flag
      set_idx(8'd11); wr_dat(8'h00);
      idle(3'b001, 0); chk("R7", {7'b0, irq}, 8'h00);
      wr_dat(8'h10); chk("R7", {7'b0, irq}, 8'h01);
      wr_dat(8'h40); chk("R7", {7'b0, irq}, 8'h00);
      set_idx(8'd12); rd_dat(v); chk("R7", v, 8'h10);

      // R8 soft clear
      set_idx(8'd11); wr_dat(8'h78);
      idle(3'b100, 0); chk("R8", {7'b0, irq}, 8'h01);
      idle(3'b000, 1); chk("R8", {7'b0, irq}, 8'h00);
      rd_dat(v); chk("R8", v, 8'h10);
      set_idx(8'd12); rd_dat(v); chk("R8", v, 8'h00);

      // R2 plain storage
      set_idx(8'h40); wr_dat(8'h5A);
      set_idx(8'h7F); wr_dat(8'hC3);
      rd_dat(v); chk("R2", v, 8'hC3);
      set_idx(8'h40); rd_dat(v); chk("R2", v, 8'h5A);
      set_idx(8'h09); rd_dat(v); chk("R2", v, 8'h00);

      // constrained random phase against the model
      for (int k = 0; k < 4000; k++) begin
         int unsigned op = $urandom % 10;
         logic [2:0] ev = (($urandom % 4) == 0) ? 3'($urandom) : 3'b000;
         bit uip = 1'($urandom);
         logic [7:0] d = 8'($urandom);
         logic [7:0] ix = (($urandom % 3) == 0) ? 8'($urandom) : 8'(10 + $urandom % 4);
         if (op < 2)      cyc(1, 0, 0, ix, ev, uip, 0);
         else if (op < 5) cyc(1, 0, 1, d, ev, uip, 0);
         else if (op < 8) cyc(0, 1, 1, d, ev, uip, 0);
         else if (op < 9) cyc(0, 1, 0, d, ev, uip, 0);
         else             cyc(0, 0, 0, d, ev, uip, ($urandom % 8) == 0);
      end
      idle(3'b000, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule